// File: doc/BRIEF.md
# DDR SDRAM command legality checker

This block is a passive, synchronous observer placed on the command bus of a four-bank DDR SDRAM. On every rising clock edge it samples the clock-enable line, chip select, the three strobe lines, the bank-select bits and the auto-precharge address bit. It turns the pin pattern into a single command code and keeps a small state machine per bank: idle, open, auto-precharge pending and precharging. A separate set of lockout timers covers the mode-register recovery window and bursts of writes with auto-precharge.

Any command that breaks a bank-state or timing rule is reported on the next clock as a one-cycle violation pulse, together with a 3-bit reason code. When a command is flagged, the checker does not apply it to its own bank model. Burst lengths in clocks and the precharge period are inputs, so the same instance can follow any device configuration. The block does not look at the data path or the strobe timing.

Top module: `ddr_cmd_guard`

## Requirements
- R1: With CKE high at both the previous and the current edge, and CS# low, the strobe pattern RAS#/CAS#/WE# decodes as follows. HHH is NOP (1), LHH is activate (2), HLH is read (3, or 4 with A10 high), HLL is write (5, or 6 with A10 high), HHL is burst stop (7), LHL is precharge (8, or 9 for all banks with A10 high), LLH is refresh (10), and LLL is mode-register set (11, or 12 for the extended register with BA0 high). CS# high is deselect (0). The code appears on `cmd_code` one clock after the edge that sampled it.
- R2: BA1:BA0 selects the bank (00 to bank 0, up to 11 to bank 3) for activate, read, write and single-bank precharge. A legal activate sets bit `ba` of `bank_open` after that edge.
- R3: A legal precharge closes its bank, or every open bank when A10 is high (BA is then ignored). The bank counts `cfg_trp` cycles before it is idle again. An activate to a bank that is still precharging gives violation code 7.
- R4: A legal read or write with A10 high keeps the bank open for `cfg_rd_burst` or `cfg_wr_burst` cycles. The bank then precharges for `cfg_trp` cycles, and only after that may it be activated again.
- R5: Mode-register set, extended mode-register set, auto refresh and self-refresh entry while any bank is not idle give violation code 2.
- R6: After a legal mode-register write, any command other than NOP or deselect on either of the next two edges gives violation code 3.
- R7: While a write with auto-precharge is still bursting (`cfg_wr_burst` edges after it), any read or write to any bank gives violation code 4.
- R8: Activating a bank that is open or has an auto-precharge pending gives violation code 5. A read or write to a bank that is not open gives code 6.
- R9: When CKE falls, a refresh pattern decodes as self-refresh entry (13). A NOP or deselect decodes as active power-down (14) if any bank is open, and as precharge power-down (15) otherwise.
- R10: When CKE rises the code is 16, and while CKE stays low the code is 17, provided the pins carry NOP or deselect. Any other pin command at a CKE rise, while CKE is low, or at a CKE fall other than the self-refresh pattern gives violation code 1.
- R11: `viol_valid` is high for exactly the one clock that follows an offending command, with `viol_code` 0 whenever it is low. A flagged command changes no bank state. Reset clears every bank and both outputs.
- R12: When several rules fail at once, the reported code follows this order: CKE (1), mode-register lockout (3), banks not idle (2), write-burst lockout (4), then the per-bank codes (7, 5, 6).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank select bits |
| a10 | input | 1 | Auto-precharge / all-banks bit |
| cfg_rd_burst | input | CNT_W | Read burst length in clocks |
| cfg_wr_burst | input | CNT_W | Write burst duration in clocks |
| cfg_trp | input | CNT_W | Precharge period in clocks |
| cmd_code | output | 5 | Decoded command, registered |
| bank_open | output | 2**BA_W | Per-bank open or auto-precharge-pending flag |
| viol_valid | output | 1 | One-cycle violation pulse |
| viol_code | output | 3 | Violation reason |

## Verification
The bench builds the checker with its defaults: two bank bits (four banks), 6-bit timer fields and a two-cycle mode-register window. The timing inputs are set short: first 2/3/2 clocks for read burst, write burst and precharge, then 4/6/3 for a second random phase. With these values, random traffic often lands on the exact edge where an auto-precharge expires or a precharge finishes, so the off-by-one boundaries of R3, R4 and R7 are reached without long idle stretches. Directed sequences cover the priority order and the clock-enable transitions.

// File: rtl/ddr_guard_pkg.sv
package ddr_guard_pkg;

  typedef enum logic [4:0] {
    C_DESEL = 5'd0,
    C_NOP   = 5'd1,
    C_ACT   = 5'd2,
    C_RD    = 5'd3,
    C_RDA   = 5'd4,
    C_WR    = 5'd5,
    C_WRA   = 5'd6,
    C_BST   = 5'd7,
    C_PRE   = 5'd8,
    C_PREA  = 5'd9,
    C_REF   = 5'd10,
    C_MRS   = 5'd11,
    C_EMRS  = 5'd12,
    C_SREF  = 5'd13,
    C_PDA   = 5'd14,
    C_PDP   = 5'd15,
    C_WAKE  = 5'd16,
    C_SLEEP = 5'd17
  } cmd_e;

  typedef enum logic [2:0] {
    V_NONE       = 3'd0,
    V_CKE        = 3'd1,
    V_BUSY_BANKS = 3'd2,
    V_MRD        = 3'd3,
    V_WAP        = 3'd4,
    V_ACT_OPEN   = 3'd5,
    V_CLOSED     = 3'd6,
    V_TRP        = 3'd7
  } viol_e;

  typedef enum logic [1:0] {
    B_IDLE = 2'd0,
    B_OPEN = 2'd1,
    B_APW  = 2'd2,
    B_RP   = 2'd3
  } bank_st_e;

  // Pin pattern to command, CKE not considered
  function automatic cmd_e pin_decode(input logic cs_n, input logic ras_n,
                                      input logic cas_n, input logic we_n,
                                      input logic a10, input logic ba0);
    cmd_e c;
    if (cs_n) begin
      c = C_DESEL;
    end else begin
      case ({ras_n, cas_n, we_n})
        3'b111:  c = C_NOP;
        3'b011:  c = C_ACT;
        3'b101:  c = a10 ? C_RDA : C_RD;
        3'b100:  c = a10 ? C_WRA : C_WR;
        3'b110:  c = C_BST;
        3'b010:  c = a10 ? C_PREA : C_PRE;
        3'b001:  c = C_REF;
        default: c = ba0 ? C_EMRS : C_MRS;
      endcase
    end
    return c;
  endfunction

  function automatic logic is_quiet(input cmd_e c);
    return (c == C_DESEL) || (c == C_NOP);
  endfunction

  function automatic logic is_rdwr(input cmd_e c);
    return (c == C_RD) || (c == C_RDA) || (c == C_WR) || (c == C_WRA);
  endfunction

  function automatic logic needs_idle(input cmd_e c);
    return (c == C_MRS) || (c == C_EMRS) || (c == C_REF) || (c == C_SREF);
  endfunction

endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
  import ddr_guard_pkg::*;
(
  input  logic cke,
  input  logic cke_q,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic a10,
  input  logic ba0,
  input  logic any_open,
  output cmd_e pin_cmd,
  output cmd_e eff_cmd,
  output logic cke_bad
);

  always_comb begin
    pin_cmd = pin_decode(cs_n, ras_n, cas_n, we_n, a10, ba0);
    eff_cmd = pin_cmd;
    cke_bad = 1'b0;
    case ({cke_q, cke})
      2'b10: begin
        if (pin_cmd == C_REF)       eff_cmd = C_SREF;
        else if (is_quiet(pin_cmd)) eff_cmd = any_open ? C_PDA : C_PDP;
        else                        cke_bad = 1'b1;
      end
      2'b01: begin
        if (is_quiet(pin_cmd)) eff_cmd = C_WAKE;
        else                   cke_bad = 1'b1;
      end
      2'b00: begin
        if (is_quiet(pin_cmd)) eff_cmd = C_SLEEP;
        else                   cke_bad = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/ddr_bank_track.sv
module ddr_bank_track
  import ddr_guard_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_go,
  input  logic             pre_go,
  input  logic             ap_go,
  input  logic [CNT_W-1:0] ap_len,
  input  logic [CNT_W-1:0] trp,
  output bank_st_e         st
);

  logic [CNT_W-1:0] cnt;
  logic             cnt_last;

  assign cnt_last = (cnt <= CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= B_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        B_IDLE: if (open_go) st <= B_OPEN;
        B_OPEN: begin
          if (ap_go) begin
            st  <= B_APW;
            cnt <= ap_len;
          end else if (pre_go) begin
            st  <= B_RP;
            cnt <= trp;
          end
        end
        B_APW: begin
          if (cnt_last) begin
            st  <= B_RP;
            cnt <= trp;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          if (cnt_last) st <= B_IDLE;
          else          cnt <= cnt - 1'b1;
        end
      endcase
    end
  end

  // R3
  rp_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == B_RP |=> (st == B_RP || st == B_IDLE));

  // R4
  apw_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == B_APW |=> (st == B_APW || st == B_RP));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == B_IDLE && !open_go) |=> st == B_IDLE);

endmodule

// File: rtl/ddr_lockouts.sv
module ddr_lockouts #(
  parameter int CNT_W   = 6,
  parameter int MRD_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mrs_go,
  input  logic             wap_go,
  input  logic [CNT_W-1:0] wr_len,
  output logic             mrd_busy,
  output logic             wap_busy
);

  localparam int MRD_W = $clog2(MRD_CYC + 1);

  logic [MRD_W-1:0] mcnt;
  logic [CNT_W-1:0] wcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mcnt <= '0;
      wcnt <= '0;
    end else begin
      if (mrs_go)            mcnt <= MRD_W'(MRD_CYC);
      else if (mcnt != '0)   mcnt <= mcnt - 1'b1;
      if (wap_go)            wcnt <= wr_len;
      else if (wcnt != '0)   wcnt <= wcnt - 1'b1;
    end
  end

  assign mrd_busy = (mcnt != '0);
  assign wap_busy = (wcnt != '0);

  // R6
  mrd_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mrs_go |=> mrd_busy);

  // R7
  wap_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wap_go && wr_len != '0) |=> wap_busy);

endmodule

// File: rtl/ddr_cmd_guard.sv
module ddr_cmd_guard
  import ddr_guard_pkg::*;
#(
  parameter int  BA_W    = 2,
  parameter int  CNT_W   = 6,
  parameter int  MRD_CYC = 2,
  localparam int BANKS   = 1 << BA_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke,
  input  logic             cs_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic [BA_W-1:0]  ba,
  input  logic             a10,
  input  logic [CNT_W-1:0] cfg_rd_burst,
  input  logic [CNT_W-1:0] cfg_wr_burst,
  input  logic [CNT_W-1:0] cfg_trp,
  output logic [4:0]       cmd_code,
  output logic [BANKS-1:0] bank_open,
  output logic             viol_valid,
  output logic [2:0]       viol_code
);

  logic             cke_q;
  bank_st_e         st [BANKS];
  logic [BANKS-1:0] is_idle, is_ready, is_rp;
  logic [BANKS-1:0] act_go, pre_go, ap_go;
  logic             all_idle, any_open;
  cmd_e             pin_cmd, eff_cmd;
  logic             cke_bad, pin_quiet;
  logic             mrd_busy, wap_busy, mrs_go, wap_go, ok;
  logic [CNT_W-1:0] ap_len;
  viol_e            viol;

  ddr_cmd_decode u_dec (
    .cke      (cke),
    .cke_q    (cke_q),
    .cs_n     (cs_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .a10      (a10),
    .ba0      (ba[0]),
    .any_open (any_open),
    .pin_cmd  (pin_cmd),
    .eff_cmd  (eff_cmd),
    .cke_bad  (cke_bad)
  );

  assign pin_quiet = is_quiet(pin_cmd);
  assign all_idle  = &is_idle;
  assign any_open  = |bank_open;

  always_comb begin
    viol = V_NONE;
    if (cke_bad)                                 viol = V_CKE;
    else if (mrd_busy && !pin_quiet)             viol = V_MRD;
    else if (needs_idle(eff_cmd) && !all_idle)   viol = V_BUSY_BANKS;
    else if (is_rdwr(eff_cmd) && wap_busy)       viol = V_WAP;
    else if (eff_cmd == C_ACT && !is_idle[ba])   viol = is_rp[ba] ? V_TRP : V_ACT_OPEN;
    else if (is_rdwr(eff_cmd) && !is_ready[ba])  viol = V_CLOSED;
  end

  assign ok     = (viol == V_NONE);
  assign mrs_go = ok && (eff_cmd == C_MRS || eff_cmd == C_EMRS);
  assign wap_go = ok && (eff_cmd == C_WRA);
  assign ap_len = (eff_cmd == C_WRA) ? cfg_wr_burst : cfg_rd_burst;

  genvar b;
  generate
    for (b = 0; b < BANKS; b++) begin : g_bank
      assign is_idle[b]   = (st[b] == B_IDLE);
      assign is_ready[b]  = (st[b] == B_OPEN);
      assign is_rp[b]     = (st[b] == B_RP);
      assign bank_open[b] = (st[b] == B_OPEN) || (st[b] == B_APW);
      assign act_go[b]    = ok && eff_cmd == C_ACT && ba == BA_W'(b);
      assign pre_go[b]    = ok && (eff_cmd == C_PREA ||
                                   (eff_cmd == C_PRE && ba == BA_W'(b)));
      assign ap_go[b]     = ok && (eff_cmd == C_RDA || eff_cmd == C_WRA) &&
                            ba == BA_W'(b);

      ddr_bank_track #(.CNT_W(CNT_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .open_go (act_go[b]),
        .pre_go  (pre_go[b]),
        .ap_go   (ap_go[b]),
        .ap_len  (ap_len),
        .trp     (cfg_trp),
        .st      (st[b])
      );
    end
  endgenerate

  ddr_lockouts #(.CNT_W(CNT_W), .MRD_CYC(MRD_CYC)) u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .mrs_go   (mrs_go),
    .wap_go   (wap_go),
    .wr_len   (cfg_wr_burst),
    .mrd_busy (mrd_busy),
    .wap_busy (wap_busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cke_q      <= 1'b1;
      cmd_code   <= 5'd0;
      viol_valid <= 1'b0;
      viol_code  <= 3'd0;
    end else begin
      cke_q      <= cke;
      cmd_code   <= eff_cmd;
      viol_valid <= !ok;
      viol_code  <= viol;
    end
  end

  // R5
  busy_refresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cke_q && cke && pin_cmd == C_REF && !all_idle) |=> viol_valid);

  // R8
  double_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cke_q && cke && pin_cmd == C_ACT && is_ready[ba]) |=> viol_valid);

  // R10
  cke_low_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_q && !cke && !pin_quiet) |=> (viol_valid && viol_code == V_CKE));

  // R2
  one_bank_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(act_go | ap_go));

endmodule

// File: tb/ddr_cmd_guard_test.sv
module ddr_cmd_guard_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = 2'd0;
  logic       a10 = 1'b0;
  logic [5:0] cfg_rd_burst = 6'd2, cfg_wr_burst = 6'd3, cfg_trp = 6'd2;
  logic [4:0] cmd_code;
  logic [3:0] bank_open;
  logic       viol_valid;
  logic [2:0] viol_code;

  always #(CLK_PERIOD/2) clk = ~clk;

  ddr_cmd_guard uut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .a10(a10),
    .cfg_rd_burst(cfg_rd_burst), .cfg_wr_burst(cfg_wr_burst), .cfg_trp(cfg_trp),
    .cmd_code(cmd_code), .bank_open(bank_open),
    .viol_valid(viol_valid), .viol_code(viol_code)
  );

  int    checks = 0, fails = 0;
  int    edge_n = 0;
  int    m_mode [4], m_apend [4], m_idle [4];
  int    m_wap_end = 0, m_mrd_end = 0;
  bit    m_cke_q = 1'b1;
  int    exp_cmd = 0, exp_v = 0;
  int    exp_open = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  // 0 idle, 1 open, 2 auto-precharge pending, 3 precharging
  function automatic int bstat(int b, int p);
    if (m_mode[b] == 1) return 1;
    if (m_mode[b] == 2) begin
      if (p < m_apend[b]) return 2;
      if (p < m_idle[b])  return 3;
    end
    return 0;
  endfunction

  function automatic int pin_code(bit cs, bit r, bit c, bit w, bit ap, bit b0);
    if (cs) return 0;
    case ({r, c, w})
      3'b111:  return 1;
      3'b011:  return 2;
      3'b101:  return ap ? 4 : 3;
      3'b100:  return ap ? 6 : 5;
      3'b110:  return 7;
      3'b010:  return ap ? 9 : 8;
      3'b001:  return 10;
      default: return b0 ? 12 : 11;
    endcase
  endfunction

  function automatic string vtag(int v);
    case (v)
      1: return "R10";
      2: return "R5";
      3: return "R6";
      4: return "R7";
      5, 6: return "R8";
      7: return "R3";
      default: return "R11";
    endcase
  endfunction

  task automatic model_step();
    int e, p, pin, eff, v, b, len;
    bit quiet, rdwr, anyo, alli;
    edge_n++;
    e = edge_n; p = e - 1; b = int'(ba);
    pin = pin_code(cs_n, ras_n, cas_n, we_n, a10, ba[0]);
    quiet = (pin <= 1);
    anyo = 1'b0; alli = 1'b1;
    for (int i = 0; i < 4; i++) begin
      if (bstat(i, p) == 1 || bstat(i, p) == 2) anyo = 1'b1;
      if (bstat(i, p) != 0) alli = 1'b0;
    end
    eff = pin; v = 0;
    if (m_cke_q && !cke) begin
      if (pin == 10) eff = 13;
      else if (quiet) eff = anyo ? 14 : 15;
      else v = 1;
    end else if (!m_cke_q && cke) begin
      if (quiet) eff = 16; else v = 1;
    end else if (!m_cke_q && !cke) begin
      if (quiet) eff = 17; else v = 1;
    end
    rdwr = (eff >= 3 && eff <= 6);
    if (v == 0) begin
      if (p < m_mrd_end && !quiet) v = 3;
      else if ((eff >= 10 && eff <= 13) && !alli) v = 2;
      else if (rdwr && p < m_wap_end) v = 4;
      else if (eff == 2 && bstat(b, p) != 0) v = (bstat(b, p) == 3) ? 7 : 5;
      else if (rdwr && bstat(b, p) != 1) v = 6;
    end
    if (v == 0) begin
      case (eff)
        2: m_mode[b] = 1;
        8: if (bstat(b, p) == 1) begin
             m_mode[b] = 2; m_apend[b] = e; m_idle[b] = e + int'(cfg_trp);
           end
        9: for (int i = 0; i < 4; i++)
             if (bstat(i, p) == 1) begin
               m_mode[i] = 2; m_apend[i] = e; m_idle[i] = e + int'(cfg_trp);
             end
        4, 6: begin
          len = (eff == 6) ? int'(cfg_wr_burst) : int'(cfg_rd_burst);
          m_mode[b] = 2; m_apend[b] = e + len; m_idle[b] = e + len + int'(cfg_trp);
          if (eff == 6) m_wap_end = e + len;
        end
        11, 12: m_mrd_end = e + 2;
        default: ;
      endcase
    end
    m_cke_q = cke;
    exp_cmd = eff; exp_v = v;
    exp_open = 0;
    for (int i = 0; i < 4; i++)
      if (bstat(i, e) == 1 || bstat(i, e) == 2) exp_open |= (1 << i);
  endtask

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s (%s) %s: actual=%0d expected=%0d", tag, cur_req, what, act, exp);
    end
  endtask

  task automatic compare();
    check((exp_cmd >= 13 && exp_cmd <= 15) ? "R9" : "R1", "cmd_code", int'(cmd_code), exp_cmd);
    check(vtag(exp_v), "viol_code", int'(viol_code), exp_v);
    check("R11", "viol_valid", int'(viol_valid), (exp_v != 0) ? 1 : 0);
    check("R2", "bank_open", int'(bank_open), exp_open);
  endtask

  // rcw = {ras_n,cas_n,we_n}
  task automatic cyc(bit ck, bit cs, logic [2:0] rcw, logic [1:0] b, bit ap);
    cke = ck; cs_n = cs; {ras_n, cas_n, we_n} = rcw; ba = b; a10 = ap;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic nop(int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 3'b111, 2'd0, 1'b0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 4; i++) begin m_mode[i] = 0; m_apend[i] = 0; m_idle[i] = 0; end
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11", "reset viol_valid", int'(viol_valid), 0);
    check("R11", "reset cmd_code", int'(cmd_code), 0);
    check("R11", "reset bank_open", int'(bank_open), 0);
    rst_n = 1'b1;

    cur_req = "R2";  cyc(1, 0, 3'b011, 2'd1, 0);   // activate bank 1
    cur_req = "R8";  cyc(1, 0, 3'b011, 2'd1, 0);   // activate open bank
    cur_req = "R8";  cyc(1, 0, 3'b101, 2'd2, 0);   // read closed bank
    cur_req = "R5";  cyc(1, 0, 3'b000, 2'd0, 0);   // mode set, bank open
    cur_req = "R7";  cyc(1, 0, 3'b011, 2'd0, 0);
    cyc(1, 0, 3'b100, 2'd1, 1);                     // write + auto-precharge bank 1
    cyc(1, 0, 3'b101, 2'd0, 0);                     // read other bank during burst
    nop(2);
    cyc(1, 0, 3'b101, 2'd0, 0);                     // R7 boundary: burst over
    cur_req = "R4";  cyc(1, 0, 3'b011, 2'd1, 0);   // still auto-precharging
    nop(1);
    cyc(1, 0, 3'b011, 2'd1, 0);                     // R4 tRP boundary
    cur_req = "R3";  cyc(1, 0, 3'b010, 2'd0, 0);   // precharge bank 0
    cyc(1, 0, 3'b011, 2'd0, 0);                     // activate in tRP
    cyc(1, 0, 3'b011, 2'd0, 0);
    cyc(1, 0, 3'b010, 2'd3, 1);                     // precharge all, BA ignored
    nop(3);
    cur_req = "R6";  cyc(1, 0, 3'b000, 2'd1, 0);   // extended mode set
    cyc(1, 0, 3'b011, 2'd2, 0);
    nop(1);
    cyc(1, 0, 3'b011, 2'd2, 0);
    cur_req = "R9";  cyc(0, 1, 3'b111, 2'd0, 0);   // active power-down
    cur_req = "R12"; cyc(0, 0, 3'b011, 2'd2, 0);   // CKE rule outranks bank rule
    cur_req = "R10"; cyc(1, 1, 3'b111, 2'd0, 0);
    cyc(1, 0, 3'b010, 2'd0, 1);
    nop(3);
    cur_req = "R9";  cyc(0, 0, 3'b001, 2'd0, 0);   // self-refresh entry
    cyc(0, 0, 3'b111, 2'd0, 0);
    cur_req = "R10"; cyc(1, 0, 3'b101, 2'd0, 0);   // command at exit
    nop(2);
    cur_req = "R12"; cyc(1, 0, 3'b000, 2'd0, 0);
    cyc(1, 0, 3'b001, 2'd0, 0);                     // lockout outranks others

    for (int phase = 0; phase < 2; phase++) begin
      if (phase == 1) begin cfg_rd_burst = 6'd4; cfg_wr_burst = 6'd6; cfg_trp = 6'd3; end
      cur_req = "random";
      for (int n = 0; n < 3000; n++) begin
        int r;
        bit ck;
        logic [2:0] rcw;
        bit cs;
        r = int'($urandom % 100);
        ck = m_cke_q ? ($urandom % 100 >= 4) : ($urandom % 100 < 40);
        cs = 1'b0;
        if (r < 5)       begin cs = 1'b1; rcw = 3'b111; end
        else if (r < 15) rcw = 3'b111;
        else if (r < 37) rcw = 3'b011;
        else if (r < 55) rcw = 3'b101;
        else if (r < 71) rcw = 3'b100;
        else if (r < 82) rcw = 3'b010;
        else if (r < 85) rcw = 3'b110;
        else if (r < 89) rcw = 3'b001;
        else if (r < 92) rcw = 3'b000;
        else             rcw = 3'b111;
        cyc(ck, cs, rcw, 2'($urandom % 4), 1'($urandom % 2));
      end
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule